// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between a handful of external interrupt pins and an interrupt controller. Each pin is first brought into the core clock domain by a two-flop synchroniser. Each input then has its own trigger mode: off, rising edge, falling edge, either edge, high level or low level. A detected condition is held in a pending bit. A per-input enable bit gates that pending bit onto one request line per input.

Software reaches four word registers through a simple write port and a combinational read port. Address bits [3:2] select the register:

- 0x0 holds the trigger settings.
- 0x4 shows the synchronised pin levels.
- 0x8 holds the pending bits.
- 0xC holds the enable bits.

A pending bit is released by writing zero to its position in 0x8 while writing ones to every position that must be kept. When an input is first brought into use, the low-level mode is the normal choice. The number of inputs is a parameter with a default and maximum of six.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset the trigger settings, pending bits, enable bits and all request outputs are zero.
- R2: Reading offset 0x4 returns in bit i the level of pin i as it was two clock edges earlier (two-flop synchroniser); writes to 0x4 change nothing.
- R3: The trigger code of input i is stored from write-data bits [4i+2:4i] of offset 0x0 and read back there; bit 4i+3 and all bits above the last input read as zero.
- R4: With code 1 (rising), 2 (falling) or 3 (either edge), an edge of the synchronised level sets the pending bit on the third clock edge after the pin changes, and the bit then stays set until software clears it, whatever the pin does.
- R5: A write to offset 0x8 clears pending bit i when write-data bit i is 0 and leaves it unchanged when that bit is 1.
- R6: With code 5 (high level) or 6 (low level) the pending bit follows the active level of the synchronised input on every clock, and clear writes have no lasting effect.
- R7: With code 0, 4 or 7 the pending bit is held at zero.
- R8: Request output i is high exactly when pending bit i and bit i of the enable register at offset 0xC are both set; 0xC reads back the enable bits.
- R9: When an edge event and a clear write reach the same input on the same clock edge, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pins_i | input | NUM_IN | Asynchronous external interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write byte offset |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 4 | Register read byte offset |
| rd_data_o | output | DATA_W | Register read data, combinational |
| irq_o | output | NUM_IN | Per-input interrupt requests |

## Verification
A software clear of the pending register and a fresh edge event on the same input can land on the same clock edge. The bench provokes this by raising a pin and then asserting the clear write two clock edges later. With that spacing, the clear reaches the pending register on exactly the edge where the synchronised edge is seen. The pending bit is then read back and must be set. The bench also covers the neighbouring case, where a clear write keeps some bits and drops others in one cycle, and compares the read-back value with the pattern it computes from the written mask.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_BOTH = 3'd3,
    TRIG_RSV4 = 3'd4,
    TRIG_HIGH = 3'd5,
    TRIG_LOW  = 3'd6,
    TRIG_RSV7 = 3'd7
  } trig_e;

  localparam int unsigned FIELD_W = 4;
  localparam int unsigned CODE_W  = 3;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_CAP  = 2'd1;
  localparam logic [1:0] SEL_PEND = 2'd2;
  localparam logic [1:0] SEL_EN   = 2'd3;

endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;

endmodule

// File: rtl/eiu_detect.sv
module eiu_detect
  import eiu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  lvl_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  output logic  pend_o
);

  logic prev_q;
  logic pend_q;
  logic rise;
  logic fall;
  logic pend_d;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  // Edge modes: new event has priority over a simultaneous clear.
  always_comb begin
    unique case (trig_i)
      TRIG_RISE: pend_d = rise | (pend_q & ~clr_i);
      TRIG_FALL: pend_d = fall | (pend_q & ~clr_i);
      TRIG_BOTH: pend_d = rise | fall | (pend_q & ~clr_i);
      TRIG_HIGH: pend_d = lvl_i;
      TRIG_LOW:  pend_d = ~lvl_i;
      default:   pend_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import eiu_pkg::*;
#(
  parameter int unsigned NUM_IN = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_IN-1:0] pins_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [3:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_IN-1:0] irq_o
);

  localparam int unsigned CFG_BITS = NUM_IN * FIELD_W;

  logic [NUM_IN-1:0]             sync_lvl;
  logic [NUM_IN-1:0][CODE_W-1:0] cfg_q;
  logic [NUM_IN-1:0]             en_q;
  logic [NUM_IN-1:0]             pend_q;
  logic [NUM_IN-1:0]             clr;
  logic                          wr_cfg;
  logic                          wr_pend;
  logic                          wr_en_reg;

  assign wr_cfg    = wr_en_i && (wr_addr_i[3:2] == SEL_CFG);
  assign wr_pend   = wr_en_i && (wr_addr_i[3:2] == SEL_PEND);
  assign wr_en_reg = wr_en_i && (wr_addr_i[3:2] == SEL_EN);

  eiu_sync #(.WIDTH(NUM_IN)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .async_i(pins_i),
    .sync_o (sync_lvl)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_cfg) begin
        for (int i = 0; i < NUM_IN; i++) begin
          cfg_q[i] <= wr_data_i[FIELD_W*i +: CODE_W];
        end
      end
      if (wr_en_reg) begin
        en_q <= wr_data_i[NUM_IN-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    assign clr[g] = wr_pend & ~wr_data_i[g];

    eiu_detect u_det (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .lvl_i (sync_lvl[g]),
      .trig_i(trig_e'(cfg_q[g])),
      .clr_i (clr[g]),
      .pend_o(pend_q[g])
    );
  end

  assign irq_o = pend_q & en_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i[3:2])
      SEL_CFG: begin
        for (int i = 0; i < NUM_IN; i++) begin
          rd_data_o[FIELD_W*i +: CODE_W] = cfg_q[i];
        end
      end
      SEL_CAP:  rd_data_o[NUM_IN-1:0] = sync_lvl;
      SEL_PEND: rd_data_o[NUM_IN-1:0] = pend_q;
      SEL_EN:   rd_data_o[NUM_IN-1:0] = en_q;
      default:  rd_data_o = '0;
    endcase
  end

  if (CFG_BITS > DATA_W) begin : g_bad_cfg
    initial $error("NUM_IN too large for DATA_W");
  end

endmodule

// File: rtl/eiu_checker.sv
module eiu_checker #(
  parameter int unsigned NUM_IN = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_i,
  input logic [NUM_IN-1:0]             pins_i,
  input logic [NUM_IN-1:0]             sync_lvl,
  input logic [NUM_IN-1:0][2:0]        cfg_q,
  input logic [NUM_IN-1:0]             pend_q,
  input logic                          wr_en_i,
  input logic [3:0]                    wr_addr_i,
  input logic [DATA_W-1:0]             wr_data_i
);

  logic [1:0] since_rst;

  always_ff @(posedge clk_i) begin
    if (rst_i) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R2: capture path lags the pins by two edges
  a_r2_sync_delay: assert property (@(posedge clk_i) disable iff (rst_i)
    (since_rst == 2'd2) |-> (sync_lvl == $past(pins_i, 2)));

  for (genvar g = 0; g < NUM_IN; g++) begin : g_chk
    logic is_edge;
    logic is_off;
    logic clr_w;
    assign is_edge = (cfg_q[g] == 3'd1) || (cfg_q[g] == 3'd2) || (cfg_q[g] == 3'd3);
    assign is_off  = (cfg_q[g] == 3'd0) || (cfg_q[g] == 3'd4) || (cfg_q[g] == 3'd7);
    assign clr_w   = wr_en_i && (wr_addr_i[3:2] == 2'd2) && !wr_data_i[g];

    // R4: edge-mode pending bit is sticky without a clear
    a_r4_edge_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
      (is_edge && pend_q[g] && !clr_w) |=> pend_q[g]);

    // R6: high-level mode tracks the synchronised level
    a_r6_level_follow: assert property (@(posedge clk_i) disable iff (rst_i)
      (cfg_q[g] == 3'd5) |=> (pend_q[g] == $past(sync_lvl[g])));

    // R7: off codes keep pending clear
    a_r7_off_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      is_off |=> !pend_q[g]);
  end

endmodule

bind ext_irq_unit eiu_checker #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .pins_i   (pins_i),
  .sync_lvl (sync_lvl),
  .cfg_q    (cfg_q),
  .pend_q   (pend_q),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i)
);

// File: tb/ext_irq_unit_test.sv
module ext_irq_unit_test;

  localparam int N = 6;
  localparam logic [31:0] ALL = 32'h3F;

  logic        clk = 1'b0;
  logic        rst;
  logic [N-1:0] pins;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic [N-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_unit #(.NUM_IN(N), .DATA_W(32)) uut (
    .clk_i(clk), .rst_i(rst), .pins_i(pins),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic set_pins(input logic [N-1:0] p, input int waits);
    @(negedge clk);
    pins = p;
    repeat (waits) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg_rep(input int c);
    logic [31:0] v = '0;
    for (int i = 0; i < N; i++) v[4*i +: 3] = 3'(c);
    return v;
  endfunction

  function automatic logic [31:0] cfg_mask(input logic [31:0] d);
    logic [31:0] v = '0;
    for (int i = 0; i < N; i++) v[4*i +: 3] = d[4*i +: 3];
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; pins = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, v); check("R1 cfg", v, 32'h0);
    rd(4'h8, v); check("R1 pend", v, 32'h0);
    rd(4'hC, v); check("R1 en", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R3 config field layout
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R3 all ones", v, cfg_mask(32'hFFFF_FFFF));
    wr(4'h0, 32'hABCD_EF19);
    rd(4'h0, v); check("R3 pattern", v, cfg_mask(32'hABCD_EF19));
    wr(4'h0, 32'h0);

    // R2 capture sweep over all pin patterns, writes ignored
    for (int p = 0; p < 64; p++) begin
      set_pins(N'(p), 3);
      wr(4'h4, ~32'(p));
      rd(4'h4, v); check("R2 capture", v, 32'(p));
    end
    set_pins('0, 4);

    // Mode sweep over every code, all inputs alike (R4 R6 R7 R8)
    wr(4'hC, ALL);
    for (int c = 0; c < 8; c++) begin
      logic [31:0] e;
      wr(4'h0, cfg_rep(c));
      set_pins('0, 4);
      wr(4'h8, 32'h0);
      rd(4'h8, v); e = (c == 6) ? ALL : 0;
      check($sformatf("R7 R6 low idle code %0d", c), v, e);
      set_pins('1, 4);
      rd(4'h8, v); e = (c == 1 || c == 3 || c == 5) ? ALL : 0;
      check($sformatf("R4 R6 after rise code %0d", c), v, e);
      check($sformatf("R8 irq code %0d", c), 32'(irq), e);
      set_pins('0, 4);
      rd(4'h8, v); e = (c == 1 || c == 2 || c == 3 || c == 6) ? ALL : 0;
      check($sformatf("R4 sticky/fall code %0d", c), v, e);
      wr(4'h8, 32'h0);
      rd(4'h8, v); e = (c == 6) ? ALL : 0;
      check($sformatf("R5 R6 clear code %0d", c), v, e);
    end

    // R5 selective clear
    wr(4'h0, cfg_rep(1));
    set_pins('1, 4);
    wr(4'h8, 32'h2A);
    rd(4'h8, v); check("R5 keep mask", v, 32'h2A);

    // R8 enable gating
    wr(4'hC, 32'h15);
    check("R8 gated off", 32'(irq), 32'h0);
    rd(4'hC, v); check("R8 en readback", v, 32'h15);
    wr(4'hC, 32'h3C);
    check("R8 partial", 32'(irq), 32'h28);

    // R9 event and clear on the same edge
    set_pins('0, 4);
    wr(4'h8, 32'h0);
    @(negedge clk); pins = 6'h01;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'h8; wr_data = 32'h0;
    @(negedge clk); wr_en = 1'b0;
    rd(4'h8, v); check("R9 set wins", v, 32'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule